// File: doc/BRIEF.md
# Conflict-Free Memory Module Selector

This block picks, for every packet headed into a bank of interleaved slow memories, which memory module will hold it. The write frame and the later read frame of each packet are known when the packet arrives, and the block's choice keeps three things apart. Packets written in the same frame go to different modules. No packet goes to a module that must serve a read in the current frame. No two packets that are read back in the same later frame share a module. With B packets per frame there are K = 3B-1 modules. In the worst case the three conflict kinds rule out B-1, B and B-1 modules, so at least one module is always left free.

The state has two parts. The first is a circular bitmap with X rows, one per future frame modulo X, each row K bits wide, where a set bit means that module holds a packet to be read in that frame. The second is a K-bit reservation vector for the frame being written. For each request the block ORs the reservation vector with the bitmap rows of the current frame and of the read frame, inverts the result, and takes the lowest-index zero bit. The result appears one cycle later, together with the slot inside the module, which is the read frame modulo X. The current frame's bitmap row is also presented all the time as a read-enable vector for retrieval. That row is cleared once its frame has passed, so a later frame that maps to the same row starts empty.

Top module: `mms_selector`

## Requirements
- R1: After reset every bitmap row and the reservation vector are zero: rd_mask reads zero for every value of cur_frame, and sel_valid and sel_err are 0.
- R2: A request raises sel_valid exactly one clock later. When accepted (sel_err = 0), sel_module is the lowest index m whose bit is clear in the reservation vector, in bitmap row cur_frame mod X and in bitmap row req_rd_frame mod X. sel_loc is req_rd_frame mod X.
- R3: Within one frame no two accepted requests receive the same module.
- R4: An accepted request never receives a module whose bit is set in rd_mask for the current frame.
- R5: After acceptance, bit sel_module of rd_mask is 1 whenever cur_frame maps to the packet's row, until that row is cleared.
- R6: A frame_start pulse empties the reservation vector before the request presented in the same cycle is evaluated.
- R7: A frame_start with cur_frame = f clears bitmap row (f-1) mod X, so the next frame that maps to that row reads rd_mask = 0 unless new packets were placed there.
- R8: A request whose offset (req_rd_frame - cur_frame) mod 2^FRW lies outside 1..X-2 returns sel_err = 2 and changes no state.
- R9: A request with no compatible module returns sel_err = 1 and changes no state.
- R10: rd_mask and rd_loc follow cur_frame in the same cycle, with rd_loc = cur_frame mod X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | First cycle of a new frame |
| cur_frame | input | FRW | Index of the frame being written |
| req_valid | input | 1 | Placement request |
| req_rd_frame | input | FRW | Frame in which the packet will be read |
| sel_valid | output | 1 | Result of the previous cycle's request |
| sel_module | output | $clog2(3B-1) | Chosen module (valid when sel_err = 0) |
| sel_loc | output | $clog2(X) | Slot inside the module |
| sel_err | output | 2 | 0 ok, 1 no module free, 2 read frame out of window |
| rd_mask | output | 3B-1 | Modules to read in cur_frame |
| rd_loc | output | $clog2(X) | Slot to read in those modules |

## Verification
A stale reservation bit shows up on the very next request, which receives a higher module index than expected. A bitmap bit that is lost or left standing shows up either as a wrong module index for a later request that shares that row, or at the latest as a wrong rd_mask when the frame of that row comes round, up to X-1 frames later. The bench runs many frames, including a wrap of the frame counter. Against an arithmetic model of both structures it compares every sel output and the rd_mask of every cycle, so a corrupted state is reported within at most one bitmap period.

// File: rtl/mms_pkg.sv
package mms_pkg;
   typedef enum logic [1:0] {
      SEL_OK    = 2'd0,
      SEL_FULL  = 2'd1,
      SEL_RANGE = 2'd2
   } sel_status_e;
endpackage

// File: rtl/mms_prio_enc.sv
module mms_prio_enc #(
   parameter int W         = 5,
   parameter int IW        = 3,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (W < 1 || (1 << IW) < W) begin : g_bad
      $error("mms_prio_enc: index width too small");
   end

   assign found = |vec;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
         end
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/mms_rowbank.sv
module mms_rowbank #(
   parameter int K  = 5,
   parameter int X  = 8,
   parameter int XW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_en,
   input  logic [XW-1:0] clr_row,
   input  logic          set_en,
   input  logic [XW-1:0] set_row,
   input  logic [K-1:0]  set_mask,
   input  logic [XW-1:0] rd_row_a,
   input  logic [XW-1:0] rd_row_b,
   output logic [K-1:0]  rd_a,
   output logic [K-1:0]  rd_b
);
   logic [X*K-1:0] flat;

   for (genvar r = 0; r < X; r++) begin : g_row
      logic [K-1:0] row_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            row_q <= '0;
         end else if (set_en && set_row == XW'(r)) begin
            row_q <= row_q | set_mask;
         end else if (clr_en && clr_row == XW'(r)) begin
            row_q <= '0;
         end
      end
      assign flat[r*K +: K] = row_q;
   end

   assign rd_a = flat[rd_row_a*K +: K];
   assign rd_b = flat[rd_row_b*K +: K];

   AST_SET_CLR_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en) |-> (set_row != clr_row)); // R7
endmodule

// File: rtl/mms_selector.sv
module mms_selector #(
   parameter int B   = 2,
   parameter int X   = 8,
   parameter int FRW = 8,
   localparam int K  = 3 * B - 1,
   localparam int MW = (K > 1) ? $clog2(K) : 1,
   localparam int XW = $clog2(X)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           frame_start,
   input  logic [FRW-1:0] cur_frame,
   input  logic           req_valid,
   input  logic [FRW-1:0] req_rd_frame,
   output logic           sel_valid,
   output logic [MW-1:0]  sel_module,
   output logic [XW-1:0]  sel_loc,
   output logic [1:0]     sel_err,
   output logic [K-1:0]   rd_mask,
   output logic [XW-1:0]  rd_loc
);
   import mms_pkg::*;

   if (B < 1) begin : g_chk_b
      $error("mms_selector: B must be at least 1");
   end
   if (X < 4 || (X & (X - 1)) != 0) begin : g_chk_x
      $error("mms_selector: X must be a power of two, at least 4");
   end
   if (FRW < XW) begin : g_chk_frw
      $error("mms_selector: frame index narrower than row index");
   end

   logic [K-1:0]   w_q, w_eff, row_f, row_d, cand, set_mask;
   logic [XW-1:0]  cur_row, d_row, clr_row;
   logic [FRW-1:0] offset;
   logic           range_ok, pe_found, accept;
   logic [MW-1:0]  pe_idx;
   sel_status_e    status;

   assign cur_row  = cur_frame[XW-1:0];
   assign d_row    = req_rd_frame[XW-1:0];
   assign clr_row  = cur_row - XW'(1);
   assign offset   = req_rd_frame - cur_frame;
   assign range_ok = (offset >= FRW'(1)) && (offset <= FRW'(X - 2));
   assign w_eff    = frame_start ? '0 : w_q;
   assign cand     = ~(w_eff | row_f | row_d);
   assign accept   = req_valid && range_ok && pe_found;
   assign set_mask = K'(1) << pe_idx;

   mms_rowbank #(.K(K), .X(X), .XW(XW)) i_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (frame_start),
      .clr_row  (clr_row),
      .set_en   (accept),
      .set_row  (d_row),
      .set_mask (set_mask),
      .rd_row_a (cur_row),
      .rd_row_b (d_row),
      .rd_a     (row_f),
      .rd_b     (row_d)
   );

   mms_prio_enc #(.W(K), .IW(MW), .LOW_FIRST(1'b1)) i_pick (
      .vec   (cand),
      .found (pe_found),
      .idx   (pe_idx)
   );

   always_comb begin
      if (!range_ok)      status = SEL_RANGE;
      else if (!pe_found) status = SEL_FULL;
      else                status = SEL_OK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_q <= '0;
      end else if (frame_start) begin
         w_q <= accept ? set_mask : '0;
      end else if (accept) begin
         w_q <= w_q | set_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_valid  <= 1'b0;
         sel_module <= '0;
         sel_loc    <= '0;
         sel_err    <= SEL_OK;
      end else begin
         sel_valid  <= req_valid;
         sel_module <= accept ? pe_idx : '0;
         sel_loc    <= accept ? d_row : '0;
         sel_err    <= req_valid ? status : SEL_OK;
      end
   end

   assign rd_mask = row_f;
   assign rd_loc  = cur_row;

   AST_PICK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> !(w_eff[pe_idx] || row_f[pe_idx] || row_d[pe_idx])); // R2
   AST_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> ($countones(w_q) <= 1)); // R6
   AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !accept && !frame_start) |=> $stable(w_q)); // R9
   AST_MODULE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> (sel_module < MW'(K))); // R3
endmodule

// File: tb/test_mms_selector.sv
module test_mms_selector;
   localparam int B = 2, X = 8, FRW = 8;
   localparam int K = 3 * B - 1;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       frame_start = 1'b0, req_valid = 1'b0;
   logic [7:0] cur_frame = '0, req_rd_frame = '0;
   logic       sel_valid;
   logic [2:0] sel_module, sel_loc, rd_loc;
   logic [1:0] sel_err;
   logic [4:0] rd_mask;

   mms_selector #(.B(B), .X(X), .FRW(FRW)) i_mms_selector (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cur_frame(cur_frame),
      .req_valid(req_valid), .req_rd_frame(req_rd_frame), .sel_valid(sel_valid),
      .sel_module(sel_module), .sel_loc(sel_loc), .sel_err(sel_err),
      .rd_mask(rd_mask), .rd_loc(rd_loc));

   always #5 clk = ~clk;

   int checks = 0, failures = 0;
   logic [4:0] mrow [X];
   logic [4:0] mw;
   int last_mod, last_err;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int r = 0; r < X; r++) mrow[r] = '0;
      mw = '0;
   endtask

   task automatic step(input bit fs, input int f, input bit rv, input int d);
      int fr, dr, off, cand, exp_mod, exp_err;
      frame_start = fs; cur_frame = 8'(f); req_valid = rv; req_rd_frame = 8'(d);
      fr = f & 7; dr = d & 7;
      #1;
      chk(rd_mask == mrow[fr], "R5 R7 R10 rd_mask", rd_mask, mrow[fr]);
      chk(rd_loc == 3'(fr), "R10 rd_loc", rd_loc, fr);
      if (fs) mw = '0;
      off = ((d & 255) - (f & 255)) & 255;
      exp_mod = 0; exp_err = 0;
      if (off < 1 || off > X - 2) exp_err = 2;
      else begin
         cand = ~(mw | mrow[fr] | mrow[dr]) & 5'h1f;
         if (cand == 0) exp_err = 1;
         else begin
            exp_mod = -1;
            for (int m = K - 1; m >= 0; m--) if (cand[m]) exp_mod = m;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk(sel_valid == rv, "R2 sel_valid", sel_valid, rv);
      if (rv) begin
         last_mod = sel_module; last_err = sel_err;
         chk(sel_err == 2'(exp_err), "R2 R8 R9 sel_err", sel_err, exp_err);
         if (exp_err == 0) begin
            chk(sel_module == 3'(exp_mod), "R2 R6 sel_module", sel_module, exp_mod);
            chk(sel_loc == 3'(dr), "R2 sel_loc", sel_loc, dr);
            chk(!mw[sel_module], "R3 module reused in frame", sel_module, exp_mod);
            chk(!mrow[fr][sel_module], "R4 module busy reading", sel_module, exp_mod);
         end
      end
      if (fs) mrow[(f - 1) & 7] = '0;
      if (rv && exp_err == 0) begin
         mw[exp_mod] = 1'b1;
         mrow[dr][exp_mod] = 1'b1;
      end
      req_valid = 1'b0; frame_start = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0; frame_start = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      lfsr = 8'h5a;
      do_reset();
      // R1: reset state
      chk(sel_valid == 1'b0, "R1 sel_valid", sel_valid, 0);
      chk(sel_err == 2'd0, "R1 sel_err", sel_err, 0);
      for (int r = 0; r < X; r++) begin
         cur_frame = 8'(r); #1;
         chk(rd_mask == 5'd0, "R1 rd_mask", rd_mask, 0);
      end
      @(negedge clk);

      // Sweep over many frames, including a frame counter wrap.
      for (int f = 0; f < 300; f++) begin
         int d0, d1;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         d0 = f + 1 + (lfsr % (X - 2));
         d1 = f + 1 + ((lfsr >> 3) % (X - 2));
         if (f % 7 == 3) d1 = f;
         if (f % 7 == 5) d1 = f + X - 1;
         step(1, f, 1, d0);
         step(0, f, 1, d1);
         step(0, f, 0, 0);
      end

      // Exhaust all modules inside one frame (R3, R9).
      do_reset();
      step(1, 0, 1, 1);
      chk(last_mod == 0 && last_err == 0, "R3 first pick", last_mod, 0);
      for (int i = 2; i <= 6; i++) begin
         step(0, 0, 1, i);
         if (i <= 5) chk(last_mod == i - 1, "R3 distinct pick", last_mod, i - 1);
      end
      chk(last_err == 1, "R9 no module left", last_err, 1);
      for (int f = 1; f <= 7; f++) begin
         step(1, f, 0, 0);
         if (f == 1) chk(rd_mask == 5'b00001, "R5 row 1 holds module 0", rd_mask, 1);
         if (f == 6) chk(rd_mask == 5'b00000, "R9 rejected packet left no trace", rd_mask, 0);
      end

      // Out-of-window read frames (R8) and row reuse (R7).
      step(1, 8, 1, 8);
      chk(last_err == 2, "R8 offset zero", last_err, 2);
      step(0, 8, 1, 15);
      chk(last_err == 2, "R8 offset X-1", last_err, 2);
      step(1, 9, 0, 0);
      chk(rd_mask == 5'b00000, "R7 row 1 reused empty", rd_mask, 0);
      for (int f = 10; f <= 15; f++) step(1, f, 0, 0);
      chk(rd_mask == 5'b00000, "R8 frame 15 untouched", rd_mask, 0);

      // R6: first request of a new frame sees an empty reservation vector.
      step(1, 16, 1, 18);
      chk(last_mod == 0, "R6 fresh frame pick", last_mod, 0);
      step(0, 16, 1, 19);
      chk(last_mod == 1, "R6 second pick", last_mod, 1);
      step(1, 17, 1, 20);
      chk(last_mod == 0, "R6 reservation cleared", last_mod, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule